// File: doc/BRIEF.md
# NOR Flash Array Program/Erase Engine

This block holds a small byte-wide memory that follows NOR flash write rules. A request port accepts two kinds of operation. A byte program sends an address and a data byte. A region erase sends an opcode and a start address. Each request is qualified by a write-enable flag. By default, programming can only clear bits. An erase sets a whole aligned region back to all ones. When write enable is low, the request is refused and a protection error is flagged.

Erase sizes are chosen by opcode:

| Opcode | Region erased |
|---|---|
| 0x20 | one small block |
| 0x52 | one mid block |
| 0xD8 | one sector |
| 0xC7 | the whole array |

The sizes of these regions, the number of sectors, and which block sizes the device supports are all parameters. In a full-size configuration the small block would be 4 KiB and the mid block 32 KiB.

An erase runs as a sweep that clears one byte every `ERASE_WAIT` cycles. While the sweep runs, `busy` is high and new requests are refused. After reset, the same sweep fills the entire array with 0xFF. A separate read port returns any byte one cycle after its address is presented, and it stays usable during erases.

Top module: `nor_array_engine`

## Requirements
- R1: `busy` is high while reset is asserted. After reset is released, `busy` stays high for exactly SECTOR_BYTES*SECTOR_COUNT*ERASE_WAIT cycles while the array is filled with 0xFF. Every byte then reads 0xFF.
- R2: With OVERWRITE=0, an accepted program (`req_erase`=0, `wr_en`=1) stores the old byte AND the new data.
- R3: With OVERWRITE=1, an accepted program stores the new data unchanged, so bits can go from 0 to 1.
- R4: A program with `wr_en`=0 leaves the byte unchanged and pulses `err_protect`.
- R5: An erase (`req_erase`=1) clears a region to 0xFF, and no byte outside that region changes. The region depends on the opcode: 0x20 clears SMALL_BYTES, 0x52 clears MID_BYTES, 0xD8 clears SECTOR_BYTES, and 0xC7 clears the whole array. The start address is first aligned down to the region size.
- R6: An accepted erase of N bytes raises `busy` on the next clock edge and holds it for exactly N*ERASE_WAIT cycles. Any request presented while `busy` is high is ignored.
- R7: An erase with a known opcode and `wr_en`=0 erases nothing, leaves `busy` low, and pulses `err_protect`.
- R8: A 0x20 erase when CAN_SMALL=0, or a 0x52 erase when CAN_MID=0, pulses `err_capability`. If `wr_en` is high, the erase is still carried out.
- R9: An erase with any other opcode pulses `err_opcode`, changes nothing, and leaves `busy` low.
- R10: `rd_data` shows the byte at `rd_addr` as sampled on the previous clock edge.
- R11: Each error flag is high only in the cycle after the request that caused it was accepted. A request is accepted when `req_valid`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_erase | input | 1 | 1 = erase, 0 = byte program |
| req_opcode | input | 8 | Erase size opcode |
| req_addr | input | AW | Program address or erase start address |
| req_data | input | 8 | Program data |
| wr_en | input | 1 | Write enable for this request |
| busy | output | 1 | Erase sweep in progress; requests are refused |
| err_protect | output | 1 | Pulse: request refused because write enable was low |
| err_capability | output | 1 | Pulse: the device lacks the requested erase size |
| err_opcode | output | 1 | Pulse: unknown erase opcode |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, one cycle latency |

## Verification
Programming is tested in two ways. Repeated programs of overlapping bit patterns to one byte show the AND rule (R2). A second instance with the overwrite option then receives the same pattern pair, which shows the two program modes apart (R3).

Each erase opcode is tested with a start address that is not aligned. Marker bytes are placed just inside and just outside the expected region. Reading these markers separates the four region sizes, confirms the alignment, and catches any sweep that stops one byte early or runs one byte late (R5). The `busy` length is counted for each erase as well (R6).

Further requests cover a refused program, a refused erase, a missing capability, an unknown opcode, and a program sent during a sweep. For each, the targeted bytes are read back to confirm that the refused or ignored request had no effect.

// File: rtl/nor_array_engine.sv
module nor_array_engine #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTOR_COUNT = 4,
  parameter int SMALL_BYTES  = 64,
  parameter int MID_BYTES    = 256,
  parameter bit CAN_SMALL    = 1'b1,
  parameter bit CAN_MID      = 1'b0,
  parameter bit OVERWRITE    = 1'b0,
  parameter int ERASE_WAIT   = 2,
  localparam int TOTAL = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic [7:0]    req_opcode,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          wr_en,
  output logic          busy,
  output logic          err_protect,
  output logic          err_capability,
  output logic          err_opcode,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int TW = $clog2(ERASE_WAIT) + 1;

  logic [7:0]    mem [TOTAL];
  logic [AW-1:0] cur, last;
  logic [TW-1:0] tick;

  logic          op_known, op_cap, op_chip;
  logic [AW-1:0] span_m1, start;

  always_comb begin
    op_known = 1'b1;
    op_cap   = 1'b1;
    op_chip  = 1'b0;
    span_m1  = AW'(SECTOR_BYTES - 1);
    case (req_opcode)
      8'h20: begin span_m1 = AW'(SMALL_BYTES - 1); op_cap = CAN_SMALL; end
      8'h52: begin span_m1 = AW'(MID_BYTES - 1);   op_cap = CAN_MID;   end
      8'hD8: span_m1 = AW'(SECTOR_BYTES - 1);
      8'hC7: begin span_m1 = AW'(TOTAL - 1); op_chip = 1'b1; end
      default: op_known = 1'b0;
    endcase
  end

  assign start = op_chip ? '0 : (req_addr & ~span_m1);

  wire accept   = req_valid && !busy;
  wire sweep_wr = busy && (tick == TW'(ERASE_WAIT - 1));
  wire prog_wr  = accept && !req_erase && wr_en;
  wire [7:0] prog_val = OVERWRITE ? req_data : (mem[req_addr] & req_data);

  always_ff @(posedge clk) begin
    if (sweep_wr)     mem[cur]      <= 8'hFF;
    else if (prog_wr) mem[req_addr] <= prog_val;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b1;
      cur            <= '0;
      last           <= AW'(TOTAL - 1);
      tick           <= '0;
      err_protect    <= 1'b0;
      err_capability <= 1'b0;
      err_opcode     <= 1'b0;
    end else begin
      err_protect    <= 1'b0;
      err_capability <= 1'b0;
      err_opcode     <= 1'b0;
      if (busy) begin
        if (sweep_wr) begin
          tick <= '0;
          if (cur == last) busy <= 1'b0;
          else             cur  <= cur + 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end else if (accept) begin
        if (!req_erase) begin
          if (!wr_en) err_protect <= 1'b1;
        end else if (!op_known) begin
          err_opcode <= 1'b1;
        end else begin
          if (!op_cap) err_capability <= 1'b1;
          if (!wr_en) begin
            err_protect <= 1'b1;
          end else begin
            busy <= 1'b1;
            cur  <= start;
            last <= start | span_m1;
            tick <= '0;
          end
        end
      end
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cur != last) |=> busy);
  // R6
  cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur <= last);
  // R11
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_protect || err_capability || err_opcode) |-> $past(req_valid && !busy));
  // R9
  opcode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_opcode |-> !busy && !err_protect && !err_capability);
  // R7
  protect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_protect |-> !busy);
  // R8
  capability_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_capability && !err_protect |-> busy);
endmodule

// File: tb/nor_array_engine_tb_top.sv
`timescale 1ns/1ps
module nor_array_engine_tb_top;
  localparam int TOTAL = 2048;
  localparam int AW = 11;
  localparam int WAIT = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_erase = 1'b0, wr_en = 1'b0;
  logic [7:0]    req_opcode = '0, req_data = '0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic          busy, err_protect, err_capability, err_opcode;
  logic [7:0]    rd_data;
  logic          busy_e, ep_e, ec_e, eo_e;
  logic [7:0]    rd_data_e;

  nor_array_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_data(req_data),
    .wr_en(wr_en), .busy(busy), .err_protect(err_protect),
    .err_capability(err_capability), .err_opcode(err_opcode),
    .rd_addr(rd_addr), .rd_data(rd_data));

  nor_array_engine #(.SECTOR_BYTES(64), .SECTOR_COUNT(2), .SMALL_BYTES(16),
                     .MID_BYTES(32), .OVERWRITE(1'b1)) dut_ee_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_opcode(req_opcode), .req_addr(req_addr[6:0]), .req_data(req_data),
    .wr_en(wr_en), .busy(busy_e), .err_protect(ep_e),
    .err_capability(ec_e), .err_opcode(eo_e),
    .rd_addr(rd_addr[6:0]), .rd_data(rd_data_e));

  int total = 0, fails = 0;
  logic [7:0] model [TOTAL];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic fp, fc, fo;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    while (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());

  task automatic do_read(int a, string tag);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk);
    #1;
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
  endtask

  task automatic req(bit er, logic [7:0] op, int a, logic [7:0] d, bit we);
    @(negedge clk);
    req_erase = er; req_opcode = op; req_addr = AW'(a); req_data = d;
    wr_en = we; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    fp = err_protect; fc = err_capability; fo = err_opcode;
  endtask

  task automatic prog(int a, logic [7:0] d);
    req(1'b0, 8'h00, a, d, 1'b1);
    model[a] = model[a] & d;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic model_erase(int lo, int n);
    for (int i = lo; i < lo + n; i++) model[i] = 8'hFF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int cyc;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    wait_idle(cyc);
    check("R1 fill cycles", cyc, TOTAL * WAIT);
    do_read(0, "R1 fill");
    do_read(2047, "R1 fill");
    while (busy_e) @(negedge clk);

    // R2 / R3
    prog(3, 8'h0F);
    prog(3, 8'hF0);
    do_read(3, "R2 and-rule");
    check("R3 overwrite", rd_data_e, 8'hF0);
    prog(5, 8'hA5);
    check("R2 no flags", {fp, fc, fo}, 0);
    prog(5, 8'h3C);
    do_read(5, "R2 and-rule");
    do_read(5, "R10 read latency");

    // R4
    req(1'b0, 8'h00, 5, 8'h00, 1'b0);
    check("R4 protect flag", fp, 1);
    do_read(5, "R4 unchanged");
    // R11
    check("R11 pulse ends", err_protect, 0);

    // R5 small block, R6 busy length
    prog(63, 8'h11); prog(64, 8'h22); prog(127, 8'h33); prog(128, 8'h44);
    req(1'b1, 8'h20, 70, 8'h00, 1'b1);
    check("R5 small flags", {fp, fc, fo}, 0);
    wait_idle(cyc);
    check("R6 small busy", cyc, 64 * WAIT);
    model_erase(64, 64);
    do_read(63, "R5 small below");
    do_read(64, "R5 small first");
    do_read(127, "R5 small last");
    do_read(128, "R5 small above");

    // R8 mid block unsupported but performed
    prog(255, 8'h01); prog(256, 8'h02); prog(511, 8'h03); prog(512, 8'h04);
    req(1'b1, 8'h52, 300, 8'h00, 1'b1);
    check("R8 capability flag", fc, 1);
    check("R8 no protect", fp, 0);
    wait_idle(cyc);
    check("R6 mid busy", cyc, 256 * WAIT);
    model_erase(256, 256);
    do_read(255, "R8 mid below");
    do_read(256, "R8 mid first");
    do_read(511, "R8 mid last");
    do_read(512, "R8 mid above");

    // R5 sector
    prog(1023, 8'h07); prog(1024, 8'h08);
    req(1'b1, 8'hD8, 1000, 8'h00, 1'b1);
    check("R5 sector flags", {fp, fc, fo}, 0);
    wait_idle(cyc);
    check("R6 sector busy", cyc, 512 * WAIT);
    model_erase(512, 512);
    do_read(512, "R5 sector first");
    do_read(1023, "R5 sector last");
    do_read(1024, "R5 sector above");

    // R7
    prog(800, 8'h66);
    req(1'b1, 8'h52, 800, 8'h00, 1'b0);
    check("R7 protect flag", fp, 1);
    check("R7 capability too", fc, 1);
    check("R7 no busy", busy, 0);
    do_read(800, "R7 unchanged");

    // R9
    req(1'b1, 8'h99, 800, 8'h00, 1'b1);
    check("R9 opcode flag", fo, 1);
    check("R9 no busy", busy, 0);
    do_read(800, "R9 unchanged");

    // R6 request during busy is ignored
    prog(1500, 8'h5A);
    req(1'b1, 8'h20, 5, 8'h00, 1'b1);
    req(1'b0, 8'h00, 1500, 8'h00, 1'b1);
    check("R6 ignored no flags", {fp, fc, fo}, 0);
    wait_idle(cyc);
    model_erase(0, 64);
    do_read(1500, "R6 ignored program");
    do_read(5, "R5 small at zero");

    // R5 whole array
    req(1'b1, 8'hC7, 1234, 8'h00, 1'b1);
    wait_idle(cyc);
    check("R6 chip busy", cyc, TOTAL * WAIT);
    model_erase(0, TOTAL);
    do_read(1500, "R5 chip");
    do_read(1024, "R5 chip");
    do_read(800, "R5 chip");
    do_read(2047, "R5 chip");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule